// File: doc/BRIEF.md
# Voted Storage Key Array

The block stores one 7-bit protection key for every 4 KB page of storage. Each logical key lives in four physical copies, and every copy carries its own parity bit. Three copies are in service and are voted; the fourth is a standby. A single access addresses a group of four logical keys, so one read returns four keys. There are 256 groups by default, and reads complete in one clock cycle.

On each read, every key is resolved on its own. Copies that are out of service, or whose parity fails, are dropped. The key is the value held by a strict majority of the copies that remain; when no strict majority exists, the key is flagged uncorrectable. Every in-service copy that was wrong on a read adds to its own error counter. When a counter reaches the limit, a control state machine copies the voted contents of the whole array into the standby. It does this using only cycles in which there is no external access. It then retires the failing copy and puts the standby in service.

The state machine has four states:
- ST_RUN: normal operation.
- ST_FILL_RD: issue the internal read of the next group.
- ST_FILL_WR: write the voted group into the standby.
- ST_SWAP: retire the failing copy and bring the standby into service.

Its transitions are:
- ST_RUN goes to ST_FILL_RD when a counter reaches the limit and the standby is unused.
- ST_FILL_RD goes to ST_FILL_WR in a cycle with no external read or write.
- ST_FILL_WR goes back to ST_FILL_RD on an external write, without advancing. Otherwise it writes the group, then goes to ST_FILL_RD for the next group, or to ST_SWAP after the last group.
- ST_SWAP goes to ST_RUN.

A copy-targeted write mode lets any copy be written on its own, with chosen parity. This is used to inject faults.

Top module: `voted_key_array`

## Requirements
- R1: After reset, rd_valid is 0, copy_active is 4'b0111 (copies 0 to 2 in service, copy 3 standby), spare_used is 0 and spare_filling is 0.
- R2: A read requested with rd_en at a clock edge gives rd_valid=1 with its result right after that edge. Key k is in rd_keys[7k+6:7k] and its error flag is rd_ue[k].
- R3: A normal write (wr_direct=0) stores each key wr_keys[7k+6:7k], with even parity, into every in-service copy. The stored parity bit is the XOR of the key bits. A read of the same group in the same cycle returns the old contents.
- R4: A copy takes part in the vote only if it is in service and its parity is good. A parity error means the XOR of the 7 key bits and the parity bit is 1. The result is the value held by a strict majority of the participating copies.
- R5: If no value holds a strict majority of the participating copies, including the case of none participating, rd_ue[k] is 1 and key k reads as 0.
- R6: A copy-targeted write (wr_direct=1) writes only the copies whose bit is set in wr_copy_sel (bit c selects copy c), whether or not they are in service. The parity of key k is inverted when wr_par_flip[k] is 1.
- R7: On each external read, an in-service copy gains one error if, for any of the four keys, it has a parity error, or it has good parity and differs from a non-uncorrectable result. The count saturates at 4.
- R8: When an in-service copy other than copy 3 reaches a count of 4 and the standby is unused, spare_filling rises two cycles after the edge that returned the fourth failing read. The lowest-numbered such copy is the one retired.
- R9: During filling, the standby receives the voted value of every group, and normal writes also reach the standby, so its contents at swap time match the voted array.
- R10: Reads keep their voted results while filling runs. At the end, spare_filling falls, the retired copy leaves copy_active, copy 3 joins it, and spare_used becomes 1.
- R11: Once spare_used is 1, no further sparing happens and copy_active no longer changes, whatever the error counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request |
| wr_direct | input | 1 | 1 selects copy-targeted write |
| wr_copy_sel | input | 4 | Copies written in copy-targeted mode |
| wr_par_flip | input | 4 | Per-key parity inversion in copy-targeted mode |
| wr_addr | input | 8 | Group written |
| wr_keys | input | 28 | Four keys, key k at bits 7k+6:7k |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Group read |
| rd_valid | output | 1 | Read result present |
| rd_keys | output | 28 | Voted keys |
| rd_ue | output | 4 | Per-key uncorrectable flag |
| copy_active | output | 4 | Copies currently in service |
| spare_filling | output | 1 | Standby is being loaded |
| spare_used | output | 1 | Standby has been brought into service |

## Verification
A wrong participation mask, a bad parity rule or a faulty vote shows on the next read as a wrong key or uncorrectable flag. Reads therefore come right after every kind of injected fault. A wrong error count shows only as a sparing start that comes early, late or on the wrong copy, within two cycles of the deciding read. The bench therefore checks spare_filling at exactly that point and checks that it stays low one read earlier. A standby that was loaded badly stays hidden until the other copies are corrupted after the swap. The bench then forces the standby to be the only good copy of a group that was written late during filling.

// File: rtl/kv_pkg.sv
package kv_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_FILL_RD,
        ST_FILL_WR,
        ST_SWAP
    } kv_state_e;
endpackage

// File: rtl/kv_copy_bank.sv
module kv_copy_bank #(
    parameter int ADDR_W = 8,
    parameter int ROW_W  = 32
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [ROW_W-1:0]  wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [ROW_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [ROW_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/kv_voter.sv
module kv_voter #(
    parameter int KEY_W  = 7,
    parameter int COPIES = 4
) (
    input  logic [COPIES*KEY_W-1:0] copy_key,
    input  logic [COPIES-1:0]       copy_par,
    input  logic [COPIES-1:0]       copy_on,
    output logic [KEY_W-1:0]        key_out,
    output logic                    key_ue,
    output logic [COPIES-1:0]       copy_bad
);
    localparam int CNT_W = $clog2(COPIES + 1);

    logic [COPIES-1:0] good;
    logic [CNT_W-1:0]  n_good;
    logic [CNT_W-1:0]  agree;

    always_comb begin
        for (int c = 0; c < COPIES; c++)
            good[c] = copy_on[c] & ~(^{copy_par[c], copy_key[c*KEY_W +: KEY_W]});
        n_good  = CNT_W'($countones(good));
        key_out = '0;
        key_ue  = 1'b1;
        agree   = '0;
        for (int c = 0; c < COPIES; c++) begin
            agree = '0;
            for (int d = 0; d < COPIES; d++)
                if (good[d] && copy_key[d*KEY_W +: KEY_W] == copy_key[c*KEY_W +: KEY_W])
                    agree = agree + CNT_W'(1);
            if (key_ue && good[c] && ({agree, 1'b0} > {1'b0, n_good})) begin
                key_ue  = 1'b0;
                key_out = copy_key[c*KEY_W +: KEY_W];
            end
        end
        for (int c = 0; c < COPIES; c++)
            copy_bad[c] = copy_on[c] &
                          (~good[c] | (~key_ue & (copy_key[c*KEY_W +: KEY_W] != key_out)));
    end
endmodule

// File: rtl/kv_spare_ctrl.sv
module kv_spare_ctrl
    import kv_pkg::*;
#(
    parameter int COPIES    = 4,
    parameter int ADDR_W    = 8,
    parameter int ERR_LIMIT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_rd,
    input  logic              ext_wr,
    input  logic              rd_valid,
    input  logic [COPIES-1:0] copy_bad,
    output logic [COPIES-1:0] copy_on,
    output logic              fill_active,
    output logic              spare_used,
    output logic              sweep_re,
    output logic              spare_we,
    output logic [ADDR_W-1:0] sweep_addr
);
    localparam int SPARE = COPIES - 1;
    localparam int CNT_W = $clog2(ERR_LIMIT + 1);
    localparam int VIC_W = (COPIES > 1) ? $clog2(COPIES) : 1;
    localparam logic [CNT_W-1:0]  LIMIT   = CNT_W'(ERR_LIMIT);
    localparam logic [COPIES-1:0] ON_INIT = {1'b0, {(COPIES-1){1'b1}}};

    kv_state_e        state, state_nx;
    logic [CNT_W-1:0] err_cnt [COPIES];
    logic [VIC_W-1:0] victim, trig_idx;
    logic             trig;

    always_comb begin
        trig     = 1'b0;
        trig_idx = '0;
        for (int c = SPARE - 1; c >= 0; c--)
            if (copy_on[c] && err_cnt[c] == LIMIT) begin
                trig     = 1'b1;
                trig_idx = VIC_W'(c);
            end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:     if (trig && !spare_used) state_nx = ST_FILL_RD;
            ST_FILL_RD: if (!ext_rd && !ext_wr) state_nx = ST_FILL_WR;
            ST_FILL_WR: if (ext_wr)             state_nx = ST_FILL_RD;
                        else if (&sweep_addr)   state_nx = ST_SWAP;
                        else                    state_nx = ST_FILL_RD;
            ST_SWAP:                            state_nx = ST_RUN;
            default:                            state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        sweep_re    = (state == ST_FILL_RD) && !ext_rd && !ext_wr;
        spare_we    = (state == ST_FILL_WR) && !ext_wr;
        fill_active = (state != ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            copy_on    <= ON_INIT;
            spare_used <= 1'b0;
            victim     <= '0;
            sweep_addr <= '0;
            for (int c = 0; c < COPIES; c++) err_cnt[c] <= '0;
        end else begin
            for (int c = 0; c < COPIES; c++)
                if (rd_valid && copy_bad[c] && err_cnt[c] != LIMIT)
                    err_cnt[c] <= err_cnt[c] + CNT_W'(1);
            if (state == ST_RUN && trig && !spare_used) begin
                victim     <= trig_idx;
                sweep_addr <= '0;
            end
            if (spare_we) sweep_addr <= sweep_addr + ADDR_W'(1);
            if (state == ST_SWAP) begin
                copy_on[victim] <= 1'b0;
                copy_on[SPARE]  <= 1'b1;
                spare_used      <= 1'b1;
            end
        end
    end

    a_r11_spare_once: assert property (@(posedge clk) disable iff (!rst_n)
        spare_used |=> (spare_used && $stable(copy_on)));
    a_r10_one_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(copy_on) == COPIES - 1);
    a_r8_fill_needs_spare: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_active) |-> !spare_used);
    a_r9_write_holds_sweep: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL_WR && ext_wr) |=> (state == ST_FILL_RD && $stable(sweep_addr)));

    for (genvar g = 0; g < COPIES; g++) begin : g_cnt_chk
        a_r7_cnt_sat: assert property (@(posedge clk) disable iff (!rst_n)
            err_cnt[g] <= LIMIT);
    end
endmodule

// File: rtl/voted_key_array.sv
module voted_key_array
    import kv_pkg::*;
#(
    parameter int KEY_W     = 7,
    parameter int KEYS      = 4,
    parameter int COPIES    = 4,
    parameter int ADDR_W    = 8,
    parameter int ERR_LIMIT = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_direct,
    input  logic [COPIES-1:0]     wr_copy_sel,
    input  logic [KEYS-1:0]       wr_par_flip,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [KEYS*KEY_W-1:0] wr_keys,
    input  logic                  rd_en,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic                  rd_valid,
    output logic [KEYS*KEY_W-1:0] rd_keys,
    output logic [KEYS-1:0]       rd_ue,
    output logic [COPIES-1:0]     copy_active,
    output logic                  spare_filling,
    output logic                  spare_used
);
    localparam int SLOT_W = KEY_W + 1;
    localparam int ROW_W  = KEYS * SLOT_W;
    localparam int SPARE  = COPIES - 1;

    logic                  sweep_re, spare_we;
    logic [ADDR_W-1:0]     sweep_addr, bank_raddr;
    logic [ROW_W-1:0]      bank_q [COPIES];
    logic [ROW_W-1:0]      norm_row, dir_row, fill_row;
    logic [COPIES*KEY_W-1:0] vk_key [KEYS];
    logic [COPIES-1:0]     vk_par [KEYS];
    logic [COPIES-1:0]     bad_k [KEYS];
    logic [COPIES-1:0]     copy_bad;

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_en;
    end

    always_comb begin
        for (int k = 0; k < KEYS; k++) begin
            norm_row[k*SLOT_W +: SLOT_W] = {^wr_keys[k*KEY_W +: KEY_W], wr_keys[k*KEY_W +: KEY_W]};
            dir_row[k*SLOT_W +: SLOT_W]  = {^wr_keys[k*KEY_W +: KEY_W] ^ wr_par_flip[k],
                                            wr_keys[k*KEY_W +: KEY_W]};
            fill_row[k*SLOT_W +: SLOT_W] = {^rd_keys[k*KEY_W +: KEY_W], rd_keys[k*KEY_W +: KEY_W]};
            for (int c = 0; c < COPIES; c++) begin
                vk_key[k][c*KEY_W +: KEY_W] = bank_q[c][k*SLOT_W +: KEY_W];
                vk_par[k][c]                = bank_q[c][k*SLOT_W + KEY_W];
            end
        end
    end

    assign bank_raddr = rd_en ? rd_addr : sweep_addr;

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        localparam bit IS_SPARE = (c == SPARE);
        logic              we_c;
        logic [ADDR_W-1:0] waddr_c;
        logic [ROW_W-1:0]  wdata_c;
        always_comb begin
            we_c = (wr_en & (wr_direct ? wr_copy_sel[c]
                                       : (copy_active[c] | (spare_filling & IS_SPARE))))
                 | (spare_we & IS_SPARE);
            if (spare_we && IS_SPARE) begin
                waddr_c = sweep_addr;
                wdata_c = fill_row;
            end else begin
                waddr_c = wr_addr;
                wdata_c = wr_direct ? dir_row : norm_row;
            end
        end
        kv_copy_bank #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) i_bank (
            .clk(clk), .we(we_c), .waddr(waddr_c), .wdata(wdata_c),
            .re(rd_en | sweep_re), .raddr(bank_raddr), .rdata(bank_q[c])
        );
    end

    for (genvar k = 0; k < KEYS; k++) begin : g_key
        kv_voter #(.KEY_W(KEY_W), .COPIES(COPIES)) i_voter (
            .copy_key(vk_key[k]), .copy_par(vk_par[k]), .copy_on(copy_active),
            .key_out(rd_keys[k*KEY_W +: KEY_W]), .key_ue(rd_ue[k]), .copy_bad(bad_k[k])
        );
    end

    always_comb begin
        copy_bad = '0;
        for (int k = 0; k < KEYS; k++) copy_bad = copy_bad | bad_k[k];
    end

    kv_spare_ctrl #(.COPIES(COPIES), .ADDR_W(ADDR_W), .ERR_LIMIT(ERR_LIMIT)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .ext_rd(rd_en), .ext_wr(wr_en), .rd_valid(rd_valid),
        .copy_bad(copy_bad), .copy_on(copy_active), .fill_active(spare_filling),
        .spare_used(spare_used), .sweep_re(sweep_re), .spare_we(spare_we),
        .sweep_addr(sweep_addr)
    );

    a_r2_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
    a_r5_ue_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ue[0]) |-> (rd_keys[KEY_W-1:0] == '0));
endmodule

// File: tb/test_voted_key_array.sv
module test_voted_key_array;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en, wr_direct, rd_en;
    logic [3:0]  wr_copy_sel, wr_par_flip;
    logic [7:0]  wr_addr, rd_addr;
    logic [27:0] wr_keys;
    logic        rd_valid;
    logic [27:0] rd_keys;
    logic [3:0]  rd_ue, copy_active;
    logic        spare_filling, spare_used;

    always #5 clk = ~clk;

    voted_key_array i_voted_key_array (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_direct(wr_direct),
        .wr_copy_sel(wr_copy_sel), .wr_par_flip(wr_par_flip), .wr_addr(wr_addr),
        .wr_keys(wr_keys), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
        .rd_keys(rd_keys), .rd_ue(rd_ue), .copy_active(copy_active),
        .spare_filling(spare_filling), .spare_used(spare_used)
    );

    bit [6:0] mk [4][256][4];
    bit       mp [4][256][4];
    bit [3:0] m_on;
    int       m_cnt [4];
    bit       m_used, m_fill, done;
    int       checks, errors;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic void vote(input int g, input int k, output bit [6:0] v, output bit ue);
        bit [6:0] vals [4];
        int n = 0;
        for (int c = 0; c < 4; c++)
            if (m_on[c] && ((^mk[c][g][k]) == mp[c][g][k])) begin
                vals[n] = mk[c][g][k];
                n++;
            end
        ue = 1'b1;
        v  = '0;
        for (int i = 0; i < n; i++) begin
            int same = 0;
            for (int j = 0; j < n; j++) if (vals[j] == vals[i]) same++;
            if (2 * same > n) begin ue = 1'b0; v = vals[i]; end
        end
    endfunction

    function automatic void expect_group(input int g, output bit [27:0] ek, output bit [3:0] eu);
        for (int k = 0; k < 4; k++) begin
            bit [6:0] v; bit u;
            vote(g, k, v, u);
            ek[k*7 +: 7] = v;
            eu[k] = u;
        end
    endfunction

    function automatic void count_errors(input int g);
        for (int c = 0; c < 4; c++) begin
            bit bad = 1'b0;
            if (!m_on[c]) continue;
            for (int k = 0; k < 4; k++) begin
                bit [6:0] v; bit u;
                vote(g, k, v, u);
                if ((^mk[c][g][k]) != mp[c][g][k]) bad = 1'b1;
                else if (!u && mk[c][g][k] != v) bad = 1'b1;
            end
            if (bad && m_cnt[c] < 4) m_cnt[c]++;
        end
    endfunction

    task automatic rd_check(input int g, input string req);
        bit [27:0] ek; bit [3:0] eu;
        expect_group(g, ek, eu);
        @(negedge clk); rd_en = 1'b1; rd_addr = 8'(g);
        @(negedge clk); rd_en = 1'b0;
        chk(rd_valid == 1'b1, "R2", "rd_valid", 64'(rd_valid), 64'd1);
        chk(rd_keys == ek && rd_ue == eu, req, "keys/ue",
            {32'(rd_ue), 32'(rd_keys)}, {32'(eu), 32'(ek)});
        count_errors(g);
    endtask

    task automatic wr_norm(input int g, input bit [27:0] keys);
        @(negedge clk); wr_en = 1'b1; wr_direct = 1'b0; wr_addr = 8'(g); wr_keys = keys;
        @(negedge clk); wr_en = 1'b0;
        for (int c = 0; c < 4; c++)
            if (m_on[c] || (m_fill && c == 3))
                for (int k = 0; k < 4; k++) begin
                    mk[c][g][k] = keys[k*7 +: 7];
                    mp[c][g][k] = ^keys[k*7 +: 7];
                end
    endtask

    task automatic wr_dir(input int g, input bit [27:0] keys, input bit [3:0] sel, input bit [3:0] flip);
        @(negedge clk); wr_en = 1'b1; wr_direct = 1'b1; wr_addr = 8'(g); wr_keys = keys;
        wr_copy_sel = sel; wr_par_flip = flip;
        @(negedge clk); wr_en = 1'b0; wr_direct = 1'b0;
        for (int c = 0; c < 4; c++)
            if (sel[c])
                for (int k = 0; k < 4; k++) begin
                    mk[c][g][k] = keys[k*7 +: 7];
                    mp[c][g][k] = (^keys[k*7 +: 7]) ^ flip[k];
                end
    endtask

    function automatic bit [27:0] model_keys(input int c, input int g);
        bit [27:0] r;
        for (int k = 0; k < 4; k++) r[k*7 +: 7] = mk[c][g][k];
        return r;
    endfunction

    task automatic maybe_spare();
        int victim = -1;
        int i;
        if (m_used) return;
        for (int c = 2; c >= 0; c--) if (m_on[c] && m_cnt[c] == 4) victim = c;
        if (victim < 0) return;
        @(negedge clk); @(negedge clk);
        chk(spare_filling == 1'b1, "R8", "spare_filling rise", 64'(spare_filling), 64'd1);
        m_fill = 1'b1;
        i = 0;
        while (spare_filling && i < 4000) begin
            if (i == 100) rd_check(20, "R10 read during fill");
            else if (i == 300) wr_norm(0, 28'h5A3C96F);
            else @(negedge clk);
            i++;
        end
        chk(spare_filling == 1'b0, "R10", "fill completes", 64'(spare_filling), 64'd0);
        for (int g = 0; g < 256; g++)
            for (int k = 0; k < 4; k++) begin
                bit [6:0] v; bit u;
                vote(g, k, v, u);
                mk[3][g][k] = v;
                mp[3][g][k] = ^v;
            end
        m_on[victim] = 1'b0;
        m_on[3] = 1'b1;
        m_used = 1'b1;
        m_fill = 1'b0;
        chk(copy_active == m_on, "R10", "copy_active after swap", 64'(copy_active), 64'(m_on));
        chk(spare_used == 1'b1, "R10", "spare_used", 64'(spare_used), 64'd1);
    endtask

    task automatic finish_up();
        if (done) return;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        bit [27:0] ek, nk; bit [3:0] eu;
        void'($urandom(32'd20240611));
        m_on = 4'b0111;
        rst_n = 1'b0; wr_en = 1'b0; wr_direct = 1'b0; rd_en = 1'b0;
        wr_copy_sel = '0; wr_par_flip = '0; wr_addr = '0; rd_addr = '0; wr_keys = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_valid == 1'b0, "R1", "rd_valid", 64'(rd_valid), 64'd0);
        chk(copy_active == 4'b0111, "R1", "copy_active", 64'(copy_active), 64'h7);
        chk(spare_used == 1'b0 && spare_filling == 1'b0, "R1", "spare flags",
            {62'd0, spare_used, spare_filling}, 64'd0);

        for (int g = 0; g < 256; g++) wr_norm(g, 28'($urandom));
        rd_check(5, "R2 R3");
        rd_check(255, "R3 top group");

        // R3 read and write of one group in the same cycle
        expect_group(6, ek, eu);
        nk = 28'($urandom);
        @(negedge clk); wr_en = 1'b1; wr_direct = 1'b0; wr_addr = 8'd6; wr_keys = nk;
        rd_en = 1'b1; rd_addr = 8'd6;
        @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
        chk(rd_keys == ek && rd_ue == eu, "R3", "read-before-write", 64'(rd_keys), 64'(ek));
        count_errors(6);
        for (int k = 0; k < 4; k++)
            for (int c = 0; c < 3; c++) begin
                mk[c][6][k] = nk[k*7 +: 7];
                mp[c][6][k] = ^nk[k*7 +: 7];
            end
        rd_check(6, "R3 new data");

        // R4 R6: one copy out-voted, one copy parity-excluded
        wr_dir(7, model_keys(1, 7) ^ 28'h2A54A95, 4'b0010, 4'b0000);
        rd_check(7, "R4 R6 outvoted copy");
        maybe_spare();
        wr_dir(9, model_keys(0, 9), 4'b0001, 4'b0010);
        rd_check(9, "R4 parity excluded");
        maybe_spare();

        // R5: copy 0 parity bad and copy 1 differing on key 2
        wr_dir(8, model_keys(0, 8), 4'b0001, 4'b0100);
        wr_dir(8, model_keys(1, 8) ^ 28'(28'h55 << 14), 4'b0010, 4'b0000);
        rd_check(8, "R5 no majority");
        chk(rd_ue == 4'b0100 && rd_keys[20:14] == 7'd0, "R5", "ue key2",
            {32'(rd_ue), 32'(rd_keys[20:14])}, {32'h4, 32'h0});
        maybe_spare();

        // R7 R8: copy 2 fails four reads in a row
        wr_dir(20, model_keys(2, 20) ^ 28'h0000001, 4'b0100, 4'b0000);
        for (int n = 0; n < 3; n++) rd_check(20, "R7 counting");
        repeat (3) @(negedge clk);
        chk(spare_filling == 1'b0, "R7", "no sparing below limit", 64'(spare_filling), 64'd0);
        rd_check(20, "R7 fourth error");
        maybe_spare();
        chk(copy_active == 4'b1011, "R8", "copy 2 retired", 64'(copy_active), 64'hB);

        // R9: standby is the only good copy of group 0, written late in the fill
        wr_dir(0, model_keys(0, 0), 4'b0011, 4'b1111);
        rd_check(0, "R9 standby content");
        rd_check(100, "R9 filled group");

        // R6: write to retired copy has no effect
        wr_dir(30, 28'($urandom), 4'b0100, 4'b0000);
        rd_check(30, "R6 retired copy ignored");

        // R11: further failures start no new sparing
        wr_dir(40, model_keys(0, 40) ^ 28'h0000080, 4'b0001, 4'b0000);
        for (int n = 0; n < 5; n++) rd_check(40, "R11 repeated errors");
        repeat (4) @(negedge clk);
        chk(copy_active == 4'b1011 && spare_filling == 1'b0, "R11", "no second sparing",
            {59'd0, spare_filling, copy_active}, 64'hB);

        // random mix after sparing
        for (int n = 0; n < 400; n++) begin
            int g = int'($urandom % 16);
            int op = int'($urandom % 4);
            if (op < 2) rd_check(g, "R4 R5 R7 random read");
            else if (op == 2) wr_norm(g, 28'($urandom));
            else wr_dir(g, 28'($urandom), 4'($urandom), (($urandom % 4) == 0) ? 4'($urandom) : 4'b0000);
        end
        chk(copy_active == 4'b1011 && spare_used == 1'b1, "R11", "state after random",
            {59'd0, spare_used, copy_active}, 64'h1B);
        finish_up();
    end
endmodule